// File: doc/BRIEF.md
# Byte-Banked 16-Bit Memory Interface

This block is the memory side of a 16-bit bus whose byte-addressed space is 1 MB (addresses 0x00000 to 0xFFFFF). Storage is split into two byte-wide banks that work on their own. One holds every even address and is wired to data lanes 7..0. The other holds every odd address and is wired to lanes 15..8. Address bits above bit 0 give the location inside a bank and go to both banks at once. Address bit 0, active low, enables the even bank. A separate active-low high-byte enable turns on the odd bank.

With these two selects a bus master can move one even byte on the lower lanes or one odd byte on the upper lanes, with its least significant bit on lane 8 and no shift down. It can also move a full aligned word in one access. Splitting a misaligned word into two accesses is left to the master.

Writes take effect at the clock edge. Reads are registered: the data and a per-lane drive flag appear one cycle after the request. Any lane whose bank was not read reports its drive flag low and carries zero.

The in-bank location width is a parameter. A full 1 MB build uses 19. The default is kept small, and address bits above the location field are then ignored, so addresses alias.

Top module: `byte_bank_mem`

## Requirements
- R1: After reset, and before any read, `laneOe` is 2'b00 and `rdData` is 16'h0000.
- R2: A write with `addr[0]`=0 and `hiEnN`=1 stores `wrData[7:0]` in the even bank at location `addr[LOC_W:1]` and leaves the odd bank unchanged.
- R3: A write with `addr[0]`=1 and `hiEnN`=0 stores `wrData[15:8]` in the odd bank at location `addr[LOC_W:1]` and leaves the even bank unchanged.
- R4: A write with `addr[0]`=0 and `hiEnN`=0 stores `wrData[7:0]` in the even bank and `wrData[15:8]` in the odd bank, both at the same location, in one access.
- R5: An even-byte read (`addr[0]`=0, `hiEnN`=1) gives, in the next cycle, `laneOe`=2'b01, the stored even byte on `rdData[7:0]`, and zero on `rdData[15:8]`.
- R6: An odd-byte read (`addr[0]`=1, `hiEnN`=0) gives, in the next cycle, `laneOe`=2'b10, the stored odd byte on `rdData[15:8]` with its LSB on bit 8, and zero on `rdData[7:0]`.
- R7: A word read (`addr[0]`=0, `hiEnN`=0) gives, in the next cycle, `laneOe`=2'b11 and `rdData` = {odd byte, even byte} of that location.
- R8: With `addr[0]`=1 and `hiEnN`=1 no bank is selected. A write changes no stored byte. A read gives `laneOe`=2'b00 and `rdData`=0 in the next cycle.
- R9: In the cycle after a cycle with `rdEn`=0, `laneOe` is 2'b00 and `rdData` is 0.
- R10: When `rdEn` and `wrEn` are both high in one cycle, the read returns the contents from before that write. A later read returns the new contents.
- R11: Only `addr[LOC_W:1]` selects the location. Addresses that differ only in bits above `LOC_W` reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the read-side registers |
| addr | input | ADDR_W (20) | Byte address; bit 0 is the active-low even-bank enable |
| hiEnN | input | 1 | Active-low odd-bank (high-byte) enable |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 2*LANE_W (16) | Write data; lanes 7..0 go to the even bank, 15..8 to the odd bank |
| rdData | output | 2*LANE_W (16) | Registered read data; undriven lanes are zero |
| laneOe | output | 2 | Per-lane drive flag for the registered read; bit 0 is the even lane, bit 1 the odd lane |

## Verification
A read and a write can land in the same cycle on the same location, and the bank must return the byte it held before that edge. The bench provokes this with simultaneous word read-write requests at several locations. It checks the returned word against its reference copy from before the update, then reads the location again and expects the new word. Byte-lane isolation is judged the same way. After a byte write to one bank, a full-word read must show the other bank's byte exactly as the reference model kept it.

// File: rtl/byte_bank_mem_pkg.sv
package byte_bank_mem_pkg;

  localparam int LANES = 2;

  typedef struct packed {
    logic [LANES-1:0] wrLane;
    logic [LANES-1:0] rdLane;
  } laneStrobe_t;

endpackage

// File: rtl/byte_bank_mem_ctrl.sv
module byte_bank_mem_ctrl
  import byte_bank_mem_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LOC_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              hiEnN,
  input  logic              rdEn,
  input  logic              wrEn,
  output laneStrobe_t       strobe,
  output logic [LOC_W-1:0]  loc
);

  logic [LANES-1:0] laneSel;
  logic             unusedAddrBits;

  // lane 0: even bank, active-low bit 0; lane 1: odd bank, active-low enable
  assign laneSel[0] = ~addr[0];
  assign laneSel[1] = ~hiEnN;

  assign strobe.wrLane = laneSel & {LANES{wrEn}};
  assign strobe.rdLane = laneSel & {LANES{rdEn}};

  assign loc = addr[LOC_W:1];

  generate
    if (ADDR_W > LOC_W + 1) begin : g_alias
      assign unusedAddrBits = ^addr[ADDR_W-1:LOC_W+1];
    end else begin : g_full
      assign unusedAddrBits = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/byte_bank_mem_datapath.sv
module byte_bank_mem_datapath
  import byte_bank_mem_pkg::*;
#(
  parameter int LOC_W  = 6,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  laneStrobe_t             strobe,
  input  logic [LOC_W-1:0]        loc,
  input  logic [LANES*LANE_W-1:0] wrData,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic [LANES-1:0]        laneOe
);

  localparam int DEPTH = 1 << LOC_W;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_bank
      logic [LANE_W-1:0] store [DEPTH];
      logic [LANE_W-1:0] rdByte;
      logic              rdOe;

      always_ff @(posedge clk) begin
        if (strobe.wrLane[g]) begin
          store[loc] <= wrData[g*LANE_W +: LANE_W];
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          rdByte <= '0;
          rdOe   <= 1'b0;
        end else begin
          rdOe   <= strobe.rdLane[g];
          rdByte <= strobe.rdLane[g] ? store[loc] : '0;
        end
      end

      assign rdData[g*LANE_W +: LANE_W] = rdByte;
      assign laneOe[g] = rdOe;
    end
  endgenerate

endmodule

// File: rtl/byte_bank_mem.sv
module byte_bank_mem
  import byte_bank_mem_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LOC_W  = 6,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                hiEnN,
  input  logic                rdEn,
  input  logic                wrEn,
  input  logic [2*LANE_W-1:0] wrData,
  output logic [2*LANE_W-1:0] rdData,
  output logic [1:0]          laneOe
);

  laneStrobe_t      strobe;
  logic [LOC_W-1:0] loc;

  byte_bank_mem_ctrl #(
    .ADDR_W(ADDR_W),
    .LOC_W (LOC_W)
  ) u_ctrl (
    .addr  (addr),
    .hiEnN (hiEnN),
    .rdEn  (rdEn),
    .wrEn  (wrEn),
    .strobe(strobe),
    .loc   (loc)
  );

  byte_bank_mem_datapath #(
    .LOC_W (LOC_W),
    .LANE_W(LANE_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .loc   (loc),
    .wrData(wrData),
    .rdData(rdData),
    .laneOe(laneOe)
  );

endmodule

// File: rtl/byte_bank_mem_chk.sv
module byte_bank_mem_chk
  import byte_bank_mem_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   addr,
  input logic                hiEnN,
  input logic                rdEn,
  input logic [2*LANE_W-1:0] rdData,
  input logic [1:0]          laneOe,
  input laneStrobe_t         strobe
);

  AST_EVEN_LANE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !addr[0] && hiEnN) |=> (laneOe == 2'b01) && (rdData[2*LANE_W-1:LANE_W] == '0)); // R5

  AST_ODD_LANE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[0] && !hiEnN) |=> (laneOe == 2'b10) && (rdData[LANE_W-1:0] == '0)); // R6

  AST_WORD_BOTH_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !addr[0] && !hiEnN) |=> (laneOe == 2'b11)); // R7

  AST_NONE_SELECTED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[0] && hiEnN) |=> (laneOe == 2'b00) && (rdData == '0)); // R8

  AST_NONE_SELECTED_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (addr[0] && hiEnN) |-> (strobe.wrLane == 2'b00)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (laneOe == 2'b00) && (rdData == '0)); // R9

endmodule

bind byte_bank_mem byte_bank_mem_chk #(
  .ADDR_W(ADDR_W),
  .LANE_W(LANE_W)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .addr  (addr),
  .hiEnN (hiEnN),
  .rdEn  (rdEn),
  .rdData(rdData),
  .laneOe(laneOe),
  .strobe(strobe)
);

// File: tb/byte_bank_mem_bench.sv
`timescale 1ns/1ps
module byte_bank_mem_bench;

  localparam int ADDR_W = 20;
  localparam int LOC_W  = 6;
  localparam int DEPTH  = 1 << LOC_W;

  logic        clk = 1'b0;
  logic        rstN;
  logic [19:0] addr;
  logic        hiEnN;
  logic        rdEn;
  logic        wrEn;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic [1:0]  laneOe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] refLo [DEPTH];
  logic [7:0] refHi [DEPTH];

  always #5 clk = ~clk;

  byte_bank_mem #(.ADDR_W(ADDR_W), .LOC_W(LOC_W), .LANE_W(8)) u_byte_bank_mem (
    .clk(clk), .rstN(rstN), .addr(addr), .hiEnN(hiEnN), .rdEn(rdEn),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .laneOe(laneOe)
  );

  function automatic logic [19:0] mkAddr(input int loc, input bit odd, input int tag);
    logic [12:0] t = 13'(tag);
    logic [5:0]  l = 6'(loc);
    return {t, l, odd};
  endfunction

  task automatic step(input logic [19:0] a, input logic hn, input logic r,
                      input logic w, input logic [15:0] d);
    addr = a; hiEnN = hn; rdEn = r; wrEn = w; wrData = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expectOut(input string req, input logic [1:0] eOe, input logic [15:0] eData);
    checks++;
    if (laneOe !== eOe || rdData !== eData) begin
      fails++;
      $display("FAIL %s: laneOe=%b rdData=%h expected laneOe=%b rdData=%h",
               req, laneOe, rdData, eOe, eData);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; addr = '0; hiEnN = 1'b1; rdEn = 1'b0; wrEn = 1'b0; wrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    expectOut("R1 reset state", 2'b00, 16'h0000);

    // R4: word writes to every location, then R7 word reads
    for (int i = 0; i < DEPTH; i++) begin
      refLo[i] = 8'((i * 7 + 3) & 8'hff);
      refHi[i] = 8'((i * 13 + 8'h51) & 8'hff);
      step(mkAddr(i, 1'b0, i * 3), 1'b0, 1'b0, 1'b1, {refHi[i], refLo[i]});
    end
    for (int i = 0; i < DEPTH; i++) begin
      step(mkAddr(i, 1'b0, 0), 1'b0, 1'b1, 1'b0, 16'h0);
      expectOut("R4 R7 word write/read", 2'b11, {refHi[i], refLo[i]});
    end

    // R2: even byte writes, high lane of wrData carries junk
    for (int i = 0; i < DEPTH; i++) begin
      refLo[i] = 8'(i) ^ 8'hA5;
      step(mkAddr(i, 1'b0, 5), 1'b1, 1'b0, 1'b1, {8'(~i), refLo[i]});
    end
    for (int i = 0; i < DEPTH; i++) begin
      step(mkAddr(i, 1'b0, 0), 1'b1, 1'b1, 1'b0, 16'h0);
      expectOut("R5 even byte read", 2'b01, {8'h00, refLo[i]});
      step(mkAddr(i, 1'b0, 0), 1'b0, 1'b1, 1'b0, 16'h0);
      expectOut("R2 odd bank untouched", 2'b11, {refHi[i], refLo[i]});
    end

    // R3: odd byte writes, low lane of wrData carries junk
    for (int i = 0; i < DEPTH; i++) begin
      refHi[i] = 8'(~(i * 5));
      step(mkAddr(i, 1'b1, 9), 1'b0, 1'b0, 1'b1, {refHi[i], 8'(i + 8'h33)});
    end
    for (int i = 0; i < DEPTH; i++) begin
      step(mkAddr(i, 1'b1, 0), 1'b0, 1'b1, 1'b0, 16'h0);
      expectOut("R6 odd byte read", 2'b10, {refHi[i], 8'h00});
      step(mkAddr(i, 1'b0, 0), 1'b0, 1'b1, 1'b0, 16'h0);
      expectOut("R3 even bank untouched", 2'b11, {refHi[i], refLo[i]});
    end

    // R8: unselected writes and reads
    for (int i = 0; i < DEPTH; i++) begin
      step(mkAddr(i, 1'b1, 2), 1'b1, 1'b1, 1'b1, 16'hDEAD);
      expectOut("R8 none selected read", 2'b00, 16'h0000);
    end
    for (int i = 0; i < DEPTH; i++) begin
      step(mkAddr(i, 1'b0, 0), 1'b0, 1'b1, 1'b0, 16'h0);
      expectOut("R8 contents kept", 2'b11, {refHi[i], refLo[i]});
    end

    // R9: idle cycle after a read
    step(mkAddr(0, 1'b0, 0), 1'b0, 1'b0, 1'b0, 16'h0);
    expectOut("R9 idle output", 2'b00, 16'h0000);
    step(mkAddr(1, 1'b0, 0), 1'b0, 1'b0, 1'b1, 16'h1234);
    refLo[1] = 8'h34; refHi[1] = 8'h12;
    expectOut("R9 write-only cycle", 2'b00, 16'h0000);

    // R10: simultaneous read and write
    for (int i = 0; i < DEPTH; i += 7) begin
      logic [15:0] newWord = 16'(i * 16'h0101 + 16'h4C2B);
      step(mkAddr(i, 1'b0, 0), 1'b0, 1'b1, 1'b1, newWord);
      expectOut("R10 read returns old", 2'b11, {refHi[i], refLo[i]});
      refHi[i] = newWord[15:8]; refLo[i] = newWord[7:0];
      step(mkAddr(i, 1'b0, 0), 1'b0, 1'b1, 1'b0, 16'h0);
      expectOut("R10 later read new", 2'b11, {refHi[i], refLo[i]});
    end

    // R11: aliasing through upper address bits
    step(mkAddr(20, 1'b0, 13'h1ABC), 1'b0, 1'b0, 1'b1, 16'hBEEF);
    refHi[20] = 8'hBE; refLo[20] = 8'hEF;
    step(mkAddr(20, 1'b1, 13'h0007), 1'b0, 1'b1, 1'b0, 16'h0);
    expectOut("R11 alias odd", 2'b10, 16'hBE00);
    step(mkAddr(20, 1'b0, 13'h1FFF), 1'b1, 1'b1, 1'b0, 16'h0);
    expectOut("R11 alias even", 2'b01, 16'h00EF);

    step('0, 1'b1, 1'b0, 1'b0, 16'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule